// File: doc/BRIEF.md
# Clock-Loss Detector with Fallback Select

This block watches a main clock from a free-running reference clock. The main clock drives a toggle flop. The reference domain resynchronises that toggle and counts the reference cycles that pass without a toggle edge. When detection is armed and the count runs out, a status bit reports the stop. The block then forces its clock-select output over to the on-chip oscillator. While that select is active, it also holds an override that keeps the low-speed oscillator running. The block only produces select and status signals. The clock multiplexer, the oscillators and the rest of the clock tree sit outside it.

Software reaches the block through one 8-bit control/status register in the reference domain. A write lands only while a separate write-permit input is high. A read returns the live contents, status included, in the same cycle as the read strobe. Hardware sets the clock-select bit when it detects a stop. Software cannot move the select back to the main clock while the stop status is still asserted.

Top module: `clkloss_guard`

## Requirements
- R1: After reset the register reads 0x04 (detection field 00, select bit 1, status 0), and `sel_osc` and `lso_force_on` are both 1.
- R2: A write strobe changes the register only when `prot_en` is 1 in the same cycle. With `prot_en` at 0 the write is dropped.
- R3: The register layout is as follows. Bits [1:0] hold the detection field, bit 2 holds the clock-select bit, bit 3 holds the read-only status and bits [7:4] always read 0. `rdata` is 0 while `rd_en` is low.
- R4: Detection runs only while the detection field is 11. With 00, 01 or 10 the status reads 0 and the select bit is not set by hardware, even with the main clock halted.
- R5: With detection at 11, status reads 1 once 16 consecutive reference cycles pass without an observed main-clock edge. Because of the two-flop synchroniser, it rises 16 to 21 reference cycles after the main clock halts.
- R6: With detection at 11 and status at 1, the clock-select bit becomes 1 at the next reference edge, and so does `sel_osc`.
- R7: A permitted write of 0 to the select bit is ignored while status is 1, and also in the very cycle the status first reads 1. The select bit stays 1.
- R8: Once main-clock edges return, status reads 0 again within a few reference cycles. The select bit stays 1 until software writes 0 to it.
- R9: `lso_force_on` is 1 exactly when the clock-select bit is 1.
- R10: A read returns the live status in bit 3 in the same cycle that `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; the register and the detector run on it |
| main_clk | input | 1 | Main clock being monitored |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| prot_en | input | 1 | Write permit; a write lands only when this is 1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; valid in the cycle of `rd_en`, else 0 |
| sel_osc | output | 1 | System clock select: 1 selects the on-chip oscillator |
| lso_force_on | output | 1 | Override holding the low-speed oscillator on |

## Verification
Two events can land in the same reference cycle: the hardware setting the select bit on a detected stop, and a software write of 0 to that same bit. The bench provokes the clash while it waits for a stop. In every cycle of the wait it issues a permitted write of 0 to the select bit and reads the register at the same time. The first cycle whose read shows status 1 therefore also carries a conflicting write. The bench judges the clash by reading back a select bit of 1 afterwards, and by confirming that the select bit read 0 in every earlier cycle of the wait. This shows the hardware set wins and the write had its normal effect until then.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;

  localparam int REG_W   = 8;
  localparam int SEL_BIT = 2;
  localparam int STS_BIT = 3;

  localparam logic [1:0] DET_OFF = 2'b00;
  localparam logic [1:0] DET_ON  = 2'b11;

  typedef struct packed {
    logic [1:0] det;
    logic       sel;
  } ctrl_t;

  // detection is armed only with the full enable code
  function automatic logic det_armed(input logic [1:0] det);
    return det == DET_ON;
  endfunction

  // next value of the clock-select bit; a hardware set outranks software
  function automatic logic next_sel(input logic cur, input logic stop,
                                    input logic wr_ok, input logic wbit);
    logic n;
    n = cur;
    if (wr_ok) n = wbit;
    if (stop)  n = 1'b1;
    return n;
  endfunction

  // readable image: reserved bits zero, live status in its slot
  function automatic logic [REG_W-1:0] pack_reg(input ctrl_t c, input logic sts);
    logic [REG_W-1:0] v;
    v = '0;
    v[1:0]    = c.det;
    v[SEL_BIT] = c.sel;
    v[STS_BIT] = sts;
    return v;
  endfunction

endpackage

// File: rtl/clkloss_toggle.sv
module clkloss_toggle (
  input  logic main_clk,
  input  logic rst_n,
  output logic tog
);
  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end
endmodule

// File: rtl/clkloss_sync.sv
module clkloss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/clkloss_watch.sv
module clkloss_watch #(
  parameter int IDLE_LIMIT = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic armed,
  input  logic tog_s,
  output logic edge_seen,
  output logic stop_seen
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_LIMIT);

  logic          tog_d;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tog_d <= 1'b0;
    else        tog_d <= tog_s;
  end

  assign edge_seen = tog_s ^ tog_d;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                  idle_cnt <= '0;
    else if (!armed || edge_seen) idle_cnt <= '0;
    else if (idle_cnt != FULL)   idle_cnt <= idle_cnt + 1'b1;
  end

  assign stop_seen = armed && (idle_cnt == FULL);
endmodule

// File: rtl/clkloss_regs.sv
module clkloss_regs
  import clkloss_pkg::*;
(
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             prot_en,
  input  logic [2:0]       wbits,
  input  logic             stop_seen,
  output ctrl_t            ctrl_q,
  output logic             armed,
  output logic             wr_ok,
  output logic [REG_W-1:0] rdata
);
  assign wr_ok = wr_en && prot_en;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.det <= DET_OFF;
      ctrl_q.sel <= 1'b1;
    end else begin
      if (wr_ok) ctrl_q.det <= wbits[1:0];
      ctrl_q.sel <= next_sel(ctrl_q.sel, stop_seen, wr_ok, wbits[SEL_BIT]);
    end
  end

  assign armed = det_armed(ctrl_q.det);
  assign rdata = rd_en ? pack_reg(ctrl_q, stop_seen) : '0;
endmodule

// File: rtl/clkloss_guard.sv
module clkloss_guard
  import clkloss_pkg::*;
#(
  parameter int IDLE_LIMIT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             main_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             prot_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             sel_osc,
  output logic             lso_force_on
);
  logic  tog;
  logic  tog_s;
  logic  armed;
  logic  edge_seen;
  logic  stop_seen;
  logic  wr_ok;
  ctrl_t ctrl_q;
  logic  unused_rsvd;

  assign unused_rsvd = ^wdata[REG_W-1:SEL_BIT+1];

  clkloss_toggle u_tog (
    .main_clk (main_clk),
    .rst_n    (rst_n),
    .tog      (tog)
  );

  clkloss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .din   (tog),
    .dout  (tog_s)
  );

  clkloss_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_watch (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .tog_s     (tog_s),
    .edge_seen (edge_seen),
    .stop_seen (stop_seen)
  );

  clkloss_regs u_regs (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .prot_en   (prot_en),
    .wbits     (wdata[SEL_BIT:0]),
    .stop_seen (stop_seen),
    .ctrl_q    (ctrl_q),
    .armed     (armed),
    .wr_ok     (wr_ok),
    .rdata     (rdata)
  );

  assign sel_osc      = ctrl_q.sel;
  assign lso_force_on = ctrl_q.sel;
endmodule

// File: rtl/clkloss_guard_chk.sv
module clkloss_guard_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       prot_en,
  input logic       sel_osc,
  input logic [1:0] det_q,
  input logic       armed,
  input logic       edge_seen,
  input logic       stop_seen,
  input logic       wr_ok
);
  // R6
  stop_sets_sel_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stop_seen |=> sel_osc);

  // R4
  idle_no_status_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !armed |-> !stop_seen);

  // R2
  locked_write_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (wr_en && !prot_en && !stop_seen) |=> ($stable(sel_osc) && $stable(det_q)));

  // R8
  resume_clears_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    edge_seen |=> !stop_seen);

  // R7
  sel_rise_cause_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(sel_osc) |-> $past(stop_seen || wr_ok));
endmodule

bind clkloss_guard clkloss_guard_chk u_chk (
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .prot_en   (prot_en),
  .sel_osc   (sel_osc),
  .det_q     (ctrl_q.det),
  .armed     (armed),
  .edge_seen (edge_seen),
  .stop_seen (stop_seen),
  .wr_ok     (wr_ok)
);

// File: tb/clkloss_guard_test.sv
module clkloss_guard_test;
  logic       ref_clk = 1'b0;
  logic       main_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       prot_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sel_osc;
  logic       lso_force_on;
  logic       main_run = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  clkloss_guard uut (
    .ref_clk      (ref_clk),
    .main_clk     (main_clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .prot_en      (prot_en),
    .wdata        (wdata),
    .rdata        (rdata),
    .sel_osc      (sel_osc),
    .lso_force_on (lso_force_on)
  );

  always #10 ref_clk = ~ref_clk;
  always begin
    #15;
    if (main_run) main_clk = ~main_clk;
  end

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // expected image built independently: det | sel<<2 | status<<3
  function automatic logic [7:0] img(input logic [1:0] d, input logic s, input logic st);
    return {4'd0, 4'(d) + 4'(s) * 4'd4 + 4'(st) * 4'd8};
  endfunction

  task automatic wr(input logic p, input logic [7:0] v);
    @(negedge ref_clk);
    wr_en = 1'b1; prot_en = p; wdata = v;
    @(negedge ref_clk);
    wr_en = 1'b0; prot_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge ref_clk);
    rd_en = 1'b1;
    #1 v = rdata;
    @(negedge ref_clk);
    rd_en = 1'b0;
  endtask

  logic [7:0] v;
  logic [7:0] exp_reg;
  int         n;
  logic       early_sel;

  initial begin
    #45 rst_n = 1'b1;
    // R1 reset state
    @(negedge ref_clk); #1;
    check("R1 sel_osc", {7'd0, sel_osc}, 8'h01);
    check("R1 lso", {7'd0, lso_force_on}, 8'h01);
    check("R3 idle rdata", rdata, 8'h00);
    rd(v);
    check("R1 reset image", v, 8'h04);

    // R2 R3 R9 sweep over all write values with and without permit
    exp_reg = 8'h04;
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 256; w++) begin
        wr(p[0], w[7:0]);
        if (p == 1) exp_reg = img(w[1:0], w[2], 1'b0);
        rd(v);
        check(p == 1 ? "R3 permitted write" : "R2 locked write", v, exp_reg);
        check("R9 lso follows sel", {7'd0, lso_force_on}, {7'd0, exp_reg[2]});
      end
    end

    // R4 halted main clock with detection off or invalid codes
    for (int d = 0; d < 3; d++) begin
      wr(1'b1, img(2'(d), 1'b0, 1'b0));
      main_run = 1'b0;
      repeat (40) @(negedge ref_clk);
      rd(v);
      check("R4 no detect", v, img(2'(d), 1'b0, 1'b0));
      main_run = 1'b1;
      repeat (5) @(negedge ref_clk);
    end

    // R5 R6 R7: arm, halt, keep writing sel=0 while polling (same-cycle clash)
    wr(1'b1, 8'h03);
    repeat (4) @(negedge ref_clk);
    main_run = 1'b0;
    n = 0;
    early_sel = 1'b0;
    @(negedge ref_clk);
    rd_en = 1'b1; wr_en = 1'b1; prot_en = 1'b1; wdata = 8'h03;
    n = 1;
    #1;
    while (rdata[3] !== 1'b1 && n < 40) begin
      if (rdata[2] !== 1'b0) early_sel = 1'b1;
      @(negedge ref_clk); #1;
      n++;
    end
    @(negedge ref_clk);
    wr_en = 1'b0; prot_en = 1'b0; rd_en = 1'b0;
    check("R5 stop latency low", {7'd0, n >= 16}, 8'h01);
    check("R5 stop latency high", {7'd0, n <= 21}, 8'h01);
    check("R7 sel held before stop", {7'd0, early_sel}, 8'h00);
    #1;
    check("R6 sel_osc after stop", {7'd0, sel_osc}, 8'h01);
    rd(v);
    check("R7 clash hardware wins", v, img(2'b11, 1'b1, 1'b1));
    wr(1'b1, 8'h03);
    rd(v);
    check("R7 write 0 ignored", v, img(2'b11, 1'b1, 1'b1));
    check("R10 live status", {7'd0, v[3]}, 8'h01);

    // R8 resume
    main_run = 1'b1;
    repeat (8) @(negedge ref_clk);
    rd(v);
    check("R8 status clears sel kept", v, img(2'b11, 1'b1, 1'b0));
    wr(1'b1, 8'h03);
    rd(v);
    check("R8 sel released", v, img(2'b11, 1'b0, 1'b0));
    check("R9 lso off", {7'd0, lso_force_on}, 8'h00);

    // R4 disarming clears status at once
    main_run = 1'b0;
    repeat (30) @(negedge ref_clk);
    wr(1'b1, 8'h00);
    rd(v);
    check("R4 disarm clears", v, img(2'b00, 1'b1, 1'b0));
    main_run = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule